// File: doc/BRIEF.md
# Sensor Frame Timing Generator

This block sequences the readout of a column-parallel image sensor. It counts master clock cycles and marks the start of each row and each frame. Between frames it holds a vertical-blank level. A row lasts the window width plus horizontal blanking. The blanking is first raised to a floor that depends on the column binning mode, and the row is then stretched to a global minimum length.

Two register contexts hold their own window height, coarse exposure (in rows) and fine exposure (in clocks). A select input picks between them. When the exposure asked for does not fit inside the readout, the vertical blanking is lengthened internally to make room for it. The configured blanking input is left untouched.

All configuration arrives on plain input ports. The block samples the whole set only on the clock edge that starts a frame, so a frame never mixes two configurations.

Top module: `sensor_frame_timer`

## Requirements
- R1: While reset is high, row_start, frame_start and vblank are low. The first clock edge with reset low starts a frame, so frame_start is high in the cycle that follows that edge.
- R2: The row period T is computed as follows. First take the effective blanking, max(hblank, floor). T is then max(win_width + effective blanking, 704) clocks. Within a frame, row_start pulses exactly every T cycles.
- R3: The blanking floor depends on bin_mode: 2'b00 gives 61 clocks, 2'b01 gives 71, and both 2'b10 and 2'b11 give 91.
- R4: Each frame holds exactly H row_start pulses, and the first one coincides with frame_start. H is the active context's height, and a height of zero counts as one.
- R5: Normal exposure is the case coarse + 2 <= H + vblank_rows. In that case vblank stays high for exactly vblank_rows × T cycles after the last row.
- R6: Long exposure is the case coarse + 2 > H + vblank_rows. In that case vblank stays high for (coarse + 2 − H) × T + fine + 4 cycles.
- R7: ctx_sel = 0 takes height, coarse and fine from the A inputs. ctx_sel = 1 takes them from the B inputs.
- R8: Configuration and ctx_sel are sampled only on the edge that starts a frame. A change made during a frame first shows in the next frame.
- R9: row_start and frame_start are one-cycle pulses, and row_start is never high together with vblank. frame_start rises in the cycle in which vblank falls. With zero blanking, the next frame starts in the cycle after the last row.
- R10: The frame period, measured from one frame_start to the next, is H × T plus the vertical-blank length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| win_width | input | 10 | Window width in columns |
| hblank | input | 10 | Requested horizontal blanking in clocks |
| vblank_rows | input | 10 | Configured vertical blanking in rows |
| bin_mode | input | 2 | Column binning: 00 none, 01 by two, 10/11 by four |
| ctx_sel | input | 1 | Context select: 0 = A, 1 = B |
| height_a | input | 10 | Context A window height in rows |
| coarse_a | input | 10 | Context A coarse exposure in rows |
| fine_a | input | 10 | Context A fine exposure in clocks |
| height_b | input | 10 | Context B window height in rows |
| coarse_b | input | 10 | Context B coarse exposure in rows |
| fine_b | input | 10 | Context B fine exposure in clocks |
| row_start | output | 1 | One-cycle pulse at the first clock of each row |
| frame_start | output | 1 | One-cycle pulse at the first clock of each frame |
| vblank | output | 1 | High for the whole vertical blanking interval |

## Verification
The checker relies on the 704-clock row floor. That floor keeps consecutive row pulses far apart, so the spacing and single-pulse properties rest on it. The checker also expects configuration to matter only at frame boundaries; it does not track input values.

The stimulus changes configuration only at falling clock edges. Heights are kept at two or three rows, and fine exposure stays below one row period, so every frame stays a few thousand cycles long. Each configuration is applied one cycle before waiting for a frame start, so the measured frame is known to have loaded it. One deliberate change made during a frame checks that the ongoing frame is unaffected.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int COL_W   = 10;
    localparam int ROW_W   = 10;
    localparam int FINE_W  = 10;
    localparam int TIME_W  = COL_W + 2;
    localparam int VLEN_W  = 24;

    localparam int MIN_ROW_CLKS    = 704;
    localparam int HB_FLOOR_NONE   = 61;
    localparam int HB_FLOOR_BIN2   = 71;
    localparam int HB_FLOOR_BIN4   = 91;
    localparam int FRAME_TAIL_CLKS = 4;
    localparam int EXPOSURE_PAD    = 2;

    typedef enum logic [1:0] {
        BIN_NONE  = 2'b00,
        BIN_TWO   = 2'b01,
        BIN_FOUR  = 2'b10,
        BIN_FOUR2 = 2'b11
    } bin_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ROWS,
        SEQ_BLANK
    } seq_state_e;

    typedef struct packed {
        logic [ROW_W-1:0]  height;
        logic [ROW_W-1:0]  coarse;
        logic [FINE_W-1:0] fine;
    } ctx_cfg_t;

    typedef struct packed {
        logic [COL_W-1:0] width;
        logic [COL_W-1:0] hblank;
        logic [ROW_W-1:0] vblank;
        bin_mode_e        bin;
        ctx_cfg_t         ctx;
    } frame_cfg_t;

    typedef struct packed {
        logic [TIME_W-1:0] row_time;
        logic [ROW_W-1:0]  rows;
        logic [VLEN_W-1:0] blank_len;
    } frame_plan_t;

    function automatic logic [COL_W-1:0] hblank_floor(input bin_mode_e m);
        case (m)
            BIN_NONE: return COL_W'(HB_FLOOR_NONE);
            BIN_TWO:  return COL_W'(HB_FLOOR_BIN2);
            default:  return COL_W'(HB_FLOOR_BIN4);
        endcase
    endfunction

endpackage

// File: rtl/sft_ctx_select.sv
module sft_ctx_select
    import sft_pkg::*;
#(
    parameter int N_CTX = 2,
    localparam int SEL_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  ctx_cfg_t         ctx_set [N_CTX],
    input  logic [SEL_W-1:0] sel,
    output ctx_cfg_t         ctx_out
);

    always_comb begin
        ctx_out = ctx_set[0];
        for (int i = 1; i < N_CTX; i++) begin
            if (sel == SEL_W'(i)) ctx_out = ctx_set[i];
        end
    end

endmodule

// File: rtl/sft_timing_calc.sv
module sft_timing_calc
    import sft_pkg::*;
#(
    parameter int MIN_ROW = MIN_ROW_CLKS,
    parameter int TAIL    = FRAME_TAIL_CLKS,
    parameter int PAD     = EXPOSURE_PAD
) (
    input  frame_cfg_t  cfg,
    output frame_plan_t plan
);

    localparam int RW1 = ROW_W + 1;

    logic [COL_W-1:0]  hb_min;
    logic [COL_W-1:0]  hb_eff;
    logic [TIME_W-1:0] raw_row;
    logic [TIME_W-1:0] row_time;
    logic [ROW_W-1:0]  rows;
    logic [RW1-1:0]    exp_rows;
    logic [RW1-1:0]    read_rows;
    logic              long_exp;
    logic [VLEN_W-1:0] span_rows;
    logic [VLEN_W-1:0] blank_len;

    always_comb begin
        hb_min    = hblank_floor(cfg.bin);
        hb_eff    = (cfg.hblank < hb_min) ? hb_min : cfg.hblank;
        raw_row   = TIME_W'(cfg.width) + TIME_W'(hb_eff);
        row_time  = (raw_row < TIME_W'(MIN_ROW)) ? TIME_W'(MIN_ROW) : raw_row;
        rows      = (cfg.ctx.height == '0) ? ROW_W'(1) : cfg.ctx.height;
        exp_rows  = RW1'(cfg.ctx.coarse) + RW1'(PAD);
        read_rows = RW1'(rows) + RW1'(cfg.vblank);
        long_exp  = exp_rows > read_rows;
        if (long_exp) span_rows = VLEN_W'(exp_rows - RW1'(rows));
        else          span_rows = VLEN_W'(cfg.vblank);
        blank_len = span_rows * VLEN_W'(row_time);
        if (long_exp) blank_len = blank_len + VLEN_W'(cfg.ctx.fine) + VLEN_W'(TAIL);
        plan.row_time  = row_time;
        plan.rows      = rows;
        plan.blank_len = blank_len;
    end

endmodule

// File: rtl/sft_sequencer.sv
module sft_sequencer
    import sft_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  frame_plan_t plan_in,
    output logic        row_start,
    output logic        frame_start,
    output logic        vblank
);

    seq_state_e        state;
    frame_plan_t       plan;
    logic [TIME_W-1:0] col;
    logic [ROW_W-1:0]  row;
    logic [VLEN_W-1:0] blank_left;
    logic              last_col;
    logic              last_row;
    logic              begin_frame;

    always_comb begin
        last_col    = col == (plan.row_time - TIME_W'(1));
        last_row    = row == (plan.rows - ROW_W'(1));
        begin_frame = (state == SEQ_IDLE)
                    | ((state == SEQ_ROWS) & last_col & last_row & (plan.blank_len == '0))
                    | ((state == SEQ_BLANK) & (blank_left == VLEN_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            plan       <= '0;
            col        <= '0;
            row        <= '0;
            blank_left <= '0;
        end else if (begin_frame) begin
            state <= SEQ_ROWS;
            plan  <= plan_in;
            col   <= '0;
            row   <= '0;
        end else begin
            case (state)
                SEQ_ROWS: begin
                    if (last_col) begin
                        col <= '0;
                        if (last_row) begin
                            state      <= SEQ_BLANK;
                            blank_left <= plan.blank_len;
                        end else begin
                            row <= row + ROW_W'(1);
                        end
                    end else begin
                        col <= col + TIME_W'(1);
                    end
                end
                SEQ_BLANK: blank_left <= blank_left - VLEN_W'(1);
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    assign row_start   = (state == SEQ_ROWS) && (col == '0);
    assign frame_start = row_start && (row == '0);
    assign vblank      = (state == SEQ_BLANK);

endmodule

// File: rtl/sensor_frame_timer.sv
module sensor_frame_timer
    import sft_pkg::*;
#(
    parameter int P_MIN_ROW = MIN_ROW_CLKS,
    parameter int P_TAIL    = FRAME_TAIL_CLKS,
    parameter int P_PAD     = EXPOSURE_PAD,
    parameter int P_N_CTX   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COL_W-1:0]  win_width,
    input  logic [COL_W-1:0]  hblank,
    input  logic [ROW_W-1:0]  vblank_rows,
    input  logic [1:0]        bin_mode,
    input  logic              ctx_sel,
    input  logic [ROW_W-1:0]  height_a,
    input  logic [ROW_W-1:0]  coarse_a,
    input  logic [FINE_W-1:0] fine_a,
    input  logic [ROW_W-1:0]  height_b,
    input  logic [ROW_W-1:0]  coarse_b,
    input  logic [FINE_W-1:0] fine_b,
    output logic              row_start,
    output logic              frame_start,
    output logic              vblank
);

    ctx_cfg_t    ctx_set [P_N_CTX];
    ctx_cfg_t    ctx_act;
    frame_cfg_t  cfg;
    frame_plan_t plan;

    always_comb begin
        ctx_set[0] = '{height: height_a, coarse: coarse_a, fine: fine_a};
        ctx_set[1] = '{height: height_b, coarse: coarse_b, fine: fine_b};
    end

    sft_ctx_select #(.N_CTX(P_N_CTX)) u_ctx (
        .ctx_set (ctx_set),
        .sel     (ctx_sel),
        .ctx_out (ctx_act)
    );

    always_comb begin
        cfg.width  = win_width;
        cfg.hblank = hblank;
        cfg.vblank = vblank_rows;
        cfg.bin    = bin_mode_e'(bin_mode);
        cfg.ctx    = ctx_act;
    end

    sft_timing_calc #(
        .MIN_ROW (P_MIN_ROW),
        .TAIL    (P_TAIL),
        .PAD     (P_PAD)
    ) u_calc (
        .cfg  (cfg),
        .plan (plan)
    );

    sft_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .plan_in     (plan),
        .row_start   (row_start),
        .frame_start (frame_start),
        .vblank      (vblank)
    );

endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
    parameter int MIN_ROW = 704
) (
    input logic clk,
    input logic rst,
    input logic row_start,
    input logic frame_start,
    input logic vblank
);

    localparam int GAP_W = 16;

    logic [GAP_W-1:0] gap;
    logic             seen_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap      <= '0;
            seen_row <= 1'b0;
        end else if (row_start) begin
            gap      <= GAP_W'(1);
            seen_row <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + GAP_W'(1);
        end
    end

    a_r2_row_spacing: assert property (@(posedge clk) disable iff (rst)
        (row_start && seen_row) |-> (gap >= GAP_W'(MIN_ROW)));

    a_r4_frame_on_row: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> row_start);

    a_r9_row_single: assert property (@(posedge clk) disable iff (rst)
        row_start |=> !row_start);

    a_r9_frame_single: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    a_r9_blank_quiet: assert property (@(posedge clk) disable iff (rst)
        vblank |-> !row_start);

    a_r9_blank_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(vblank) |-> frame_start);

endmodule

bind sensor_frame_timer sft_checker #(.MIN_ROW(P_MIN_ROW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .row_start   (row_start),
    .frame_start (frame_start),
    .vblank      (vblank)
);

// File: tb/sensor_frame_timer_tb.sv
module sensor_frame_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] win_width, hblank, vblank_rows;
    logic [1:0] bin_mode;
    logic       ctx_sel;
    logic [9:0] height_a, coarse_a, fine_a, height_b, coarse_b, fine_b;
    logic       row_start, frame_start, vblank;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_total = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sensor_frame_timer u_dut (
        .clk(clk), .rst(rst), .win_width(win_width), .hblank(hblank),
        .vblank_rows(vblank_rows), .bin_mode(bin_mode), .ctx_sel(ctx_sel),
        .height_a(height_a), .coarse_a(coarse_a), .fine_a(fine_a),
        .height_b(height_b), .coarse_b(coarse_b), .fine_b(fine_b),
        .row_start(row_start), .frame_start(frame_start), .vblank(vblank)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_row(input int w, input int hb, input int bin);
        int fl = (bin == 0) ? 61 : (bin == 1) ? 71 : 91;
        int h = (hb < fl) ? fl : hb;
        return (w + h < 704) ? 704 : w + h;
    endfunction

    function automatic int exp_blank(input int h, input int vb, input int c, input int f, input int t);
        if (c + 2 > h + vb) return (c + 2 - h) * t + f + 4;
        return vb * t;
    endfunction

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 190000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc_total);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic set_cfg(input int w, input int hb, input int vb, input int bin, input int sel,
                           input int ha, input int ca, input int fa,
                           input int hbb, input int cb, input int fb);
        win_width = 10'(w); hblank = 10'(hb); vblank_rows = 10'(vb);
        bin_mode = 2'(bin); ctx_sel = 1'(sel);
        height_a = 10'(ha); coarse_a = 10'(ca); fine_a = 10'(fa);
        height_b = 10'(hbb); coarse_b = 10'(cb); fine_b = 10'(fb);
    endtask

    // Measures one frame from frame_start to the next frame_start.
    // When mid is set, ctx_sel is flipped 50 cycles into the frame (R8).
    task automatic run_frame(input string tag, input int t, input int h, input int vlen, input bit mid);
        int cyc = 0, rows = 0, last = -1, bad_gap = 0, vbc = 0;
        while (!frame_start) @(negedge clk);
        forever begin
            if (row_start) begin
                if (last >= 0 && cyc - last != t) bad_gap++;
                rows++;
                last = cyc;
            end
            if (vblank) vbc++;
            if (mid && cyc == 50) ctx_sel = ~ctx_sel;
            @(negedge clk);
            cyc++;
            if (frame_start) break;
        end
        check({tag, " R2 row period mismatches"}, bad_gap, 0);
        check({tag, " R4 rows per frame"}, rows, h);
        check({tag, " R5/R6 vblank cycles"}, vbc, vlen);
        check({tag, " R10 frame period"}, cyc, h * t + vlen);
    endtask

    task automatic new_frame(input string tag, input int w, input int hb, input int vb, input int bin,
                             input int sel, input int ha, input int ca, input int fa,
                             input int hbb, input int cb, input int fb);
        int t = exp_row(w, hb, bin);
        int h = (sel == 0) ? ha : hbb;
        int c = (sel == 0) ? ca : cb;
        int f = (sel == 0) ? fa : fb;
        set_cfg(w, hb, vb, bin, sel, ha, ca, fa, hbb, cb, fb);
        @(negedge clk);
        run_frame(tag, t, h, exp_blank(h, vb, c, f, t), 0);
    endtask

    initial begin
        set_cfg(800, 30, 2, 0, 0, 3, 1, 0, 2, 0, 0);
        repeat (3) @(negedge clk);
        // R1: quiet while reset is held
        check("R1 strobes during reset", {29'd0, row_start, frame_start, vblank}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 frame_start after release", frame_start, 1);
        check("R1 row_start with frame_start", row_start, 1);
        run_frame("first", 861, 3, 2 * 861, 0);

        // R3: blanking floor per bin_mode
        new_frame("R3 bin none", 800, 30, 2, 0, 0, 3, 1, 0, 2, 0, 0);
        new_frame("R3 bin two", 800, 30, 2, 1, 0, 3, 1, 0, 2, 0, 0);
        new_frame("R3 bin four", 800, 30, 2, 2, 0, 3, 1, 0, 2, 0, 0);
        new_frame("R3 bin four alt", 800, 30, 2, 3, 0, 3, 1, 0, 2, 0, 0);
        // R2: row floor of 704 and blanking above floor
        new_frame("R2 narrow", 100, 100, 2, 0, 0, 3, 1, 0, 2, 0, 0);
        new_frame("R2 wide blank", 100, 700, 1, 0, 0, 2, 0, 0, 2, 0, 0);
        // R5/R6 boundary: coarse+2 == H+VB is normal, one more is long
        new_frame("R5 equal", 100, 100, 2, 0, 0, 3, 3, 40, 2, 0, 0);
        new_frame("R6 just long", 100, 100, 2, 0, 0, 3, 4, 20, 2, 0, 0);
        new_frame("R6 long", 700, 90, 2, 1, 0, 3, 10, 50, 2, 0, 0);
        // R7: context B
        new_frame("R7 ctx B", 800, 61, 1, 0, 1, 3, 1, 0, 2, 6, 33);
        new_frame("R7 ctx A", 800, 61, 1, 0, 0, 3, 1, 0, 2, 6, 33);
        // R9: zero blanking, frames back to back
        new_frame("R9 no blank", 100, 100, 0, 0, 0, 2, 0, 0, 2, 0, 0);

        // R8: ctx_sel flipped mid-frame; current frame keeps A, next uses B
        set_cfg(800, 61, 1, 0, 0, 2, 0, 0, 3, 7, 11);
        @(negedge clk);
        run_frame("R8 current frame", 861, 2, 861, 1);
        run_frame("R8 next frame", 861, 3, (7 + 2 - 3) * 861 + 11 + 4, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule